// File: doc/BRIEF.md
# Watchdog Timer with Fixed-Length Reset Pulse

This block is a supervisory timer that sits on a peripheral clock. The input clock first goes through a programmable prescaler and then through a selectable power-of-two divider. Together they produce a count tick that decrements a 16-bit counter. When the count runs out, the block reloads the counter from a data register, latches a sticky interrupt flag and, if reset is enabled, drives a system reset pulse of fixed length. The interrupt and the reset each have their own enable. A debug-halt input blocks the reset pulse so that a stopped processor is not reset.

Software reaches four registers through a single-cycle write port and a combinational read port: control, reload data, live count and interrupt clear. Writing the count register "kicks" the watchdog. The new value replaces the count at once, and the tick chain restarts so that a full tick period follows. With reset disabled and the interrupt enabled, the block works as a periodic interval timer.

Top module: `guard_timer`

## Requirements
- R1: After reset, control reads 0 (timer stopped, both enables off), reload data reads 0x8000, count reads 0x8000, and `irq` and `sys_rst` are low.
- R2: While enabled, one count tick occurs every (P+1)×D clocks. P is control bits [15:8]. D is chosen by control bits [4:3]: 00=16, 01=32, 10=64, 11=128.
- R3: On a tick the counter decrements by one. A tick that finds the count at 1 or 0 is a timeout: the counter loads the reload-data value (address 1) and counting continues.
- R4: Setting the enable bit (control bit 5) leaves the counter value untouched. The reload-data value is not copied into the counter.
- R5: A write to the count register (address 2) replaces the count in the same cycle and clears the prescaler and divider, so the next tick comes a full (P+1)×D clocks later.
- R6: Clearing the enable bit freezes the counter and the tick chain. The count is kept and reads back unchanged.
- R7: Every timeout sets a sticky flag. It is set whatever the interrupt enable (control bit 2) is. `irq` equals flag AND interrupt enable. Any write to address 3 clears the flag, unless a timeout occurs in the same cycle.
- R8: A timeout with reset enabled (control bit 0) makes `sys_rst` high for exactly 128 consecutive clocks.
- R9: A timeout while `dbg_halt` is high never starts a reset pulse. The counter and the flag still behave as in R3 and R7.
- R10: Reads are combinational. Address 0 returns the control fields in their write positions, address 1 returns the reload data, address 2 returns the live count, and address 3 returns the flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 2 | Register address: 0 control, 1 reload data, 2 count, 3 interrupt clear/flag |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| dbg_halt | input | 1 | Processor is in debug state; blocks the reset pulse |
| irq | output | 1 | Interrupt request, level |
| sys_rst | output | 1 | System reset pulse, active high |

## Verification
The bench measures the tick period with edge-exact reads under three prescaler and divider settings. A chain that is off by one clock reads a stale or an early count. Kicks during running are checked to restart the chain; a design that keeps the old divider phase decrements too early. The bench counts the reset pulse clock by clock, so a pulse one cycle short or long fails, and it holds debug-halt across a timeout to catch a design that still resets. It also checks that enabling does not load the reload value, that disabling freezes the count, that the flag stays sticky under a disabled interrupt enable, and that the reload happens on timeout.

// File: rtl/guard_timer.sv
module guard_timer #(
  parameter int CW    = 16,
  parameter int PW    = 8,
  parameter int PULSE = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  input  logic          dbg_halt,
  output logic          irq,
  output logic          sys_rst
);
  localparam int DIVW = 7;
  localparam int PLW  = $clog2(PULSE + 1);
  localparam logic [CW-1:0] RELOAD_INIT = CW'(1) << (CW - 1);

  logic [PW-1:0]   psc;
  logic            run, int_en, rst_en;
  logic [1:0]      dsel;
  logic [CW-1:0]   reload, cnt;
  logic [PW-1:0]   pre_cnt;
  logic [DIVW-1:0] div_cnt;
  logic            flag;
  logic [PLW-1:0]  pls;

  logic wr_ctrl, wr_data, kick, wr_clr;
  assign wr_ctrl = bus_wr && bus_addr == 2'd0;
  assign wr_data = bus_wr && bus_addr == 2'd1;
  assign kick    = bus_wr && bus_addr == 2'd2;
  assign wr_clr  = bus_wr && bus_addr == 2'd3;

  logic [DIVW-1:0] div_top;
  logic pre_wrap, tick, timeout;
  assign div_top  = DIVW'((16 << dsel) - 1);
  assign pre_wrap = pre_cnt == psc;
  assign tick     = run && pre_wrap && div_cnt == div_top;
  assign timeout  = tick && !kick && cnt <= CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      psc <= '0; run <= 1'b0; dsel <= '0; int_en <= 1'b0; rst_en <= 1'b0;
    end else if (wr_ctrl) begin
      psc    <= bus_wdata[8 +: PW];
      run    <= bus_wdata[5];
      dsel   <= bus_wdata[4:3];
      int_en <= bus_wdata[2];
      rst_en <= bus_wdata[0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       reload <= RELOAD_INIT;
    else if (wr_data) reload <= bus_wdata[CW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (kick) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (run) begin
      if (pre_wrap) begin
        pre_cnt <= '0;
        div_cnt <= (div_cnt == div_top) ? '0 : div_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt <= RELOAD_INIT;
    else if (kick)    cnt <= bus_wdata[CW-1:0];
    else if (timeout) cnt <= reload;
    else if (tick)    cnt <= cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       flag <= 1'b0;
    else if (timeout) flag <= 1'b1;
    else if (wr_clr)  flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                               pls <= '0;
    else if (pls != '0)                       pls <= pls - 1'b1;
    else if (timeout && rst_en && !dbg_halt)  pls <= PLW'(PULSE);

  assign sys_rst = pls != '0;
  assign irq     = flag && int_en;

  always_comb
    case (bus_addr)
      2'd0:    bus_rdata = {psc, 2'b00, run, dsel, int_en, 1'b0, rst_en};
      2'd1:    bus_rdata = 16'(reload);
      2'd2:    bus_rdata = 16'(cnt);
      default: bus_rdata = {15'd0, flag};
    endcase

  logic [PLW:0] run_len;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       run_len <= '0;
    else if (sys_rst) run_len <= run_len + 1'b1;
    else              run_len <= '0;

  a_r8_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= (PLW+1)'(PULSE));
  a_r8_pulse_full: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst && run_len < (PLW+1)'(PULSE - 1)) |=> sys_rst);
  a_r9_no_reset_in_debug: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> !$past(dbg_halt));
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !kick) |=> $stable(cnt));
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !wr_clr) |=> flag);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !timeout) |=> !flag);
endmodule

// File: tb/guard_timer_test.sv
module guard_timer_test;
  logic clk = 0, rst_n = 0, bus_wr = 0, dbg_halt = 0;
  logic [1:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic irq, sys_rst;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  guard_timer uut (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
                   .dbg_halt, .irq, .sys_rst);

  localparam logic [15:0] RUN = 16'h0020, IE = 16'h0004, RE = 16'h0001;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  function automatic logic [15:0] ctl(int p, int sel, logic [15:0] bits);
    return 16'(p << 8) | 16'(sel << 3) | bits;
  endfunction

  task automatic rd(logic [1:0] a, output int v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stop_all();
    wr(0, 16'h0000); wr(3, 0);
  endtask

  task automatic t_reset();
    int v;
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 data", v, 16'h8000);
    rd(2, v); chk("R1 count", v, 16'h8000);
    chk("R1 irq", irq, 0);
    chk("R1 sys_rst", sys_rst, 0);
  endtask

  task automatic t_readback();
    int v;
    wr(0, ctl(8'hA5, 2, IE | RE));
    rd(0, v); chk("R10 ctrl readback", v, 16'hA515);
    wr(1, 16'h1234);
    rd(1, v); chk("R10 data readback", v, 16'h1234);
    wr(0, 0);
  endtask

  task automatic t_enable_no_load();
    int v;
    wr(1, 7); wr(2, 3);
    wr(0, ctl(0, 0, RUN));
    rd(2, v); chk("R4 enable keeps count", v, 3);
    stop_all();
  endtask

  task automatic t_period(int p, int sel);
    int v, per;
    per = (p + 1) * (16 << sel);
    wr(1, 100); wr(2, 50);
    wr(0, ctl(p, sel, RUN));
    wait_n(per - 1);
    rd(2, v); chk("R2 before tick", v, 50);
    wait_n(1);
    rd(2, v); chk("R2 first tick", v, 49);
    wait_n(per);
    rd(2, v); chk("R3 second tick", v, 48);
    stop_all();
  endtask

  task automatic t_reload_irq();
    int v;
    wr(3, 0);
    wr(1, 2); wr(2, 2);
    wr(0, ctl(0, 0, RUN));
    wait_n(31);
    rd(3, v); chk("R7 no flag yet", v, 0);
    wait_n(1);
    rd(2, v); chk("R3 reload", v, 2);
    rd(3, v); chk("R7 flag set", v, 1);
    chk("R7 irq gated off", irq, 0);
    wait_n(16);
    rd(2, v); chk("R3 keeps counting", v, 1);
    wr(0, ctl(0, 0, RUN | IE));
    chk("R7 irq when enabled", irq, 1);
    wait_n(5);
    chk("R7 sticky", irq, 1);
    wr(3, 0);
    chk("R7 cleared", irq, 0);
    stop_all();
  endtask

  task automatic t_kick();
    int v;
    wr(1, 100); wr(2, 40);
    wr(0, ctl(0, 0, RUN));
    wait_n(10);
    wr(2, 5);
    wait_n(15);
    rd(2, v); chk("R5 full period after kick", v, 5);
    wait_n(1);
    rd(2, v); chk("R5 tick after kick", v, 4);
    stop_all();
  endtask

  task automatic t_freeze();
    int v;
    wr(1, 100); wr(2, 20);
    wr(0, ctl(0, 0, RUN));
    wait_n(19);
    wr(0, 0);
    rd(2, v); chk("R6 count before freeze", v, 19);
    wait_n(100);
    rd(2, v); chk("R6 frozen", v, 19);
    stop_all();
  endtask

  task automatic pulse_test(bit dbg, string req, int exp_len);
    int len, v;
    bit seen;
    len = 0; seen = 0;
    dbg_halt = dbg;
    wr(1, 16'h8000); wr(2, 1);
    wr(0, ctl(0, 0, RUN | RE));
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (sys_rst) begin seen = 1; len++; end
    end
    chk(req, len, exp_len);
    rd(3, v); chk({req, " flag"}, v, 1);
    dbg_halt = 0;
    stop_all();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_n(3); rst_n = 1; wait_n(1);
    t_reset();
    t_readback();
    t_enable_no_load();
    t_period(0, 0);
    t_period(2, 0);
    t_period(0, 3);
    t_reload_irq();
    t_kick();
    t_freeze();
    pulse_test(0, "R8 pulse length", 128);
    pulse_test(1, "R9 debug suppresses", 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule